// File: doc/BRIEF.md
# Runtime-Reconfigurable Folded Bit-Plane FIR Filter

The block is a FIR filter. Each output word is the sum, over the taps, of a coefficient times a delayed input sample. Every coefficient product is broken into single-bit partial products. A partial product for tap j and bit b adds the sample times that coefficient bit, weighted by 2^b. With kc taps of mc bits, the total number of elementary operations is L = kc*mc.

A fixed array of K processing cells executes all L operations over N clock slots, so L must equal K*N. Operation p runs in cell p mod K during slot p mod N. This needs K and N to be coprime, which the default values K=3 and N=4 are. The operation belongs to tap p / mc and coefficient bit p mod mc. Because of this, the same array can run 12 taps of 1-bit coefficients or 1 tap of a 12-bit coefficient without any change to the hardware. The number of cells matches the number of cells in one bit-plane of the unfolded array.

Samples come in word-parallel, one per frame of N cycles, using a valid/ready pair. Each finished sum leaves on a registered output with a one-cycle valid pulse. A configuration write selects the tap count and the coefficient width. A coefficient write loads one tap. Either write flushes the filter.

Top module: `fbp_fir`

## Requirements
- R1: After a synchronous active-high reset, the outputs read as follows: in_ready=1, out_valid=0, out_data=0, cfg_err=0. The active configuration is K taps of N bits, and all coefficients and the sample history are zero.
- R2: Each output equals sum over j<kc of c_j*x(i-j), computed at full precision. Samples are signed two's complement of DW bits. Coefficient c_j is the low mc bits of its stored word, read as signed two's complement, so bit mc-1 carries weight -2^(mc-1). History entries older than the last flush count as zero.
- R3: A sample is taken on a rising edge where in_valid=1 and in_ready=1. Its result appears with out_valid=1 exactly N+1 cycles after that edge, for one cycle. in_ready is low while a frame is running, except in the frame's last slot, so back-to-back samples yield one output every N cycles.
- R4: A configuration write with cfg_taps*cfg_bits = K*N (both nonzero) adopts the new kc and mc, clears cfg_err, zeroes the sample history and drops any frame in flight without an output pulse.
- R5: A configuration write whose product differs from K*N sets cfg_err and leaves the active configuration, the history and any running frame untouched.
- R6: A coefficient write stores coef_data as the word for tap coef_addr (taps 0..K*N-1). Only the low mc bits take part. The write flushes the filter as in R4.
- R7: Operation p (0 <= p < K*N) executes in cell p mod K at slot p mod N, and it covers tap p / mc and bit p mod mc. The results are correct for every factorization kc*mc = K*N.
- R8: With kc=2, mc=6, c0=5 and c1=-3, the inputs x0=7 and then x1=-2 give y0=35 and y1=c1*x0+c0*x1=-31.
- R9: out_data holds its last value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_taps | input | $clog2(K*N+1) | Requested tap count kc |
| cfg_bits | input | $clog2(K*N+1) | Requested coefficient width mc |
| cfg_err | output | 1 | Last configuration write was rejected |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(K*N) | Tap index of the coefficient write |
| coef_data | input | K*N | Coefficient word, low mc bits used |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle if valid |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output word valid (one-cycle pulse) |
| out_data | output | DW+K*N+1 | Signed filter output |

## Verification
The bench builds the filter with K=3, N=4 and DW=8, which makes L=12. These values put all six factorizations of 12 within reach, from twelve 1-bit taps to one 12-bit tap, including the 2-tap, 6-bit case with its known result. Because 3 and 4 are coprime, the two modulo rules fold every operation onto a distinct cell and slot pair. Random coefficient words with unused upper bits, bursts of samples with and without gaps, a rejected configuration during streaming and a coefficient write during a running frame are all compared against a behavioural direct-form model on every clock.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  // Operation index executed by cell s in slot r: p mod k == s and p mod n == r.
  function automatic int fold_op(input int s, input int r, input int k, input int n);
    int res;
    res = 0;
    for (int p = 0; p < k * n; p++) begin
      if ((p % k) == s && (p % n) == r) res = p;
    end
    return res;
  endfunction
endpackage

// File: rtl/fbp_ctrl.sv
module fbp_ctrl #(
  parameter int N = 4,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          running,
  output logic [SW-1:0] slot,
  output logic          done
);
  logic          run_q;
  logic [SW-1:0] slot_q;
  logic          done_q;
  logic          last;

  assign last     = run_q && (slot_q == SW'(N - 1));
  assign in_ready = !run_q || last;
  assign accept   = in_valid && in_ready && !flush;
  assign running  = run_q;
  assign slot     = slot_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        run_q  <= 1'b1;
        slot_q <= '0;
      end else if (last) begin
        run_q  <= 1'b0;
        slot_q <= '0;
      end else if (run_q) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  // R3: an accepted sample opens a frame at slot 0
  p_accept_starts_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (run_q && slot_q == '0));

  // R3: a running frame advances one slot per cycle until its last slot
  p_slot_steps_r3: assert property (@(posedge clk) disable iff (rst)
    (run_q && !last && !flush) |=> (run_q && slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/fbp_cell.sv
module fbp_cell #(
  parameter int K  = 3,
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int S  = 0,
  localparam int L  = K * N,
  localparam int CW = L,
  localparam int OW = DW + L + 1,
  localparam int TW = $clog2(L + 1),
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic [SW-1:0]        slot,
  input  logic [TW-1:0]        kc,
  input  logic [TW-1:0]        mc,
  input  logic [L*DW-1:0]      x_flat,
  input  logic [L*CW-1:0]      c_flat,
  output logic signed [OW-1:0] acc
);
  int                  op_p;
  int                  mcv;
  int                  tap;
  int                  bitn;
  logic [DW-1:0]       xv;
  logic                cbit;
  logic signed [OW-1:0] mag;
  logic signed [OW-1:0] term;

  always_comb begin
    op_p = fbp_pkg::fold_op(S, int'(slot), K, N);
    mcv  = (mc == '0) ? 1 : int'(mc);
    tap  = op_p / mcv;
    bitn = op_p % mcv;
    if (tap >= L) tap = 0;
    xv   = x_flat[tap*DW +: DW];
    cbit = c_flat[tap*CW + bitn];
    mag  = OW'($signed(xv)) <<< bitn;
    if (!cbit)                term = '0;
    else if (bitn == mcv - 1) term = -mag;
    else                      term = mag;
  end

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (active) acc <= (slot == '0) ? term : acc + term;
  end

  // R7: every operation a running cell executes belongs to a configured tap
  p_tap_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    active |-> (tap < int'(kc)));
endmodule

// File: rtl/fbp_fir.sv
module fbp_fir #(
  parameter int K  = 3,
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int L  = K * N,
  localparam int CW = L,
  localparam int OW = DW + L + 1,
  localparam int TW = $clog2(L + 1),
  localparam int AW = (L > 1) ? $clog2(L) : 1,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [TW-1:0]        cfg_taps,
  input  logic [TW-1:0]        cfg_bits,
  output logic                 cfg_err,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_addr,
  input  logic [CW-1:0]        coef_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  logic          cfg_ok;
  logic          flush;
  logic [TW-1:0] kc_q;
  logic [TW-1:0] mc_q;
  logic          accept;
  logic          running;
  logic [SW-1:0] slot;
  logic          done;

  logic [CW-1:0] coef_mem [L];
  logic [DW-1:0] dline    [L];
  logic [L*CW-1:0] c_flat;
  logic [L*DW-1:0] x_flat;
  logic signed [OW-1:0] acc_w [K];
  logic signed [OW-1:0] sum;

  assign cfg_ok = (cfg_taps != '0) && (cfg_bits != '0) &&
                  ((32'(cfg_taps) * 32'(cfg_bits)) == 32'(L));
  assign flush  = (cfg_we && cfg_ok) || coef_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      kc_q    <= TW'(K);
      mc_q    <= TW'(N);
      cfg_err <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_ok) begin
        kc_q    <= cfg_taps;
        mc_q    <= cfg_bits;
        cfg_err <= 1'b0;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < L; t++) coef_mem[t] <= '0;
    end else if (coef_we && (32'(coef_addr) < 32'(L))) begin
      coef_mem[coef_addr] <= coef_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int t = 0; t < L; t++) dline[t] <= '0;
    end else if (accept) begin
      dline[0] <= in_data;
      for (int t = 1; t < L; t++) dline[t] <= dline[t-1];
    end
  end

  generate
    for (genvar t = 0; t < L; t++) begin : g_flat
      assign c_flat[t*CW +: CW] = coef_mem[t];
      assign x_flat[t*DW +: DW] = dline[t];
    end
  endgenerate

  fbp_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .accept(accept), .running(running),
    .slot(slot), .done(done)
  );

  generate
    for (genvar g = 0; g < K; g++) begin : g_cell
      fbp_cell #(.K(K), .N(N), .DW(DW), .S(g)) u_cell (
        .clk(clk), .rst(rst), .active(running), .slot(slot),
        .kc(kc_q), .mc(mc_q), .x_flat(x_flat), .c_flat(c_flat),
        .acc(acc_w[g])
      );
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int g = 0; g < K; g++) sum = sum + acc_w[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= done;
      if (done) out_data <= sum;
    end
  end

  // R4: the active configuration always covers exactly K*N operations
  p_cfg_product_r4: assert property (@(posedge clk) disable iff (rst)
    (32'(kc_q) * 32'(mc_q)) == 32'(L));

  // R4: a flush cancels the running frame and any pending output
  p_flush_drops_r4: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && !running));

  // R5: a rejected configuration keeps the active one and raises the flag
  p_bad_cfg_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_ok) |=> (cfg_err && $stable(kc_q) && $stable(mc_q)));

  // R3: an output pulse only follows the end of a frame
  p_out_after_frame_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(done));
endmodule

// File: tb/tb_fbp_fir.sv
module tb_fbp_fir;
  localparam int K  = 3;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int L  = K * N;
  localparam int CW = L;
  localparam int OW = DW + L + 1;
  localparam int TW = $clog2(L + 1);
  localparam int AW = $clog2(L);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [TW-1:0] cfg_taps = '0;
  logic [TW-1:0] cfg_bits = '0;
  logic cfg_err;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  always #4 clk = ~clk;

  fbp_fir #(.K(K), .N(N), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_taps(cfg_taps),
    .cfg_bits(cfg_bits), .cfg_err(cfg_err), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string ctx = "R1 reset";

  // behavioural model state
  int m_kc, m_mc;
  logic [CW-1:0] m_coef [L];
  longint m_hist [L];
  bit m_run, m_done, m_ov, m_err, m_acc;
  int m_slot;
  longint m_cur, m_fin, m_od;

  function automatic longint coef_val(int j);
    longint v = 0;
    for (int b = 0; b < m_mc; b++)
      if (m_coef[j][b]) v += (b == m_mc - 1) ? -(64'sd1 <<< b) : (64'sd1 <<< b);
    return v;
  endfunction

  function automatic longint ref_y();
    longint y = 0;
    for (int j = 0; j < m_kc; j++) y += coef_val(j) * m_hist[j];
    return y;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] at %0t: actual=%0d expected=%0d", tag, ctx, $time, act, exp);
    end
  endtask

  task automatic advance();
    bit ok, fl, rdy, acc, last;
    if (rst) begin
      m_kc = K; m_mc = N; m_run = 0; m_done = 0; m_ov = 0; m_err = 0; m_acc = 0;
      m_slot = 0; m_cur = 0; m_fin = 0; m_od = 0;
      for (int t = 0; t < L; t++) begin m_coef[t] = '0; m_hist[t] = 0; end
      return;
    end
    ok   = (cfg_taps != 0) && (cfg_bits != 0) && (int'(cfg_taps) * int'(cfg_bits) == L);
    fl   = (cfg_we && ok) || coef_we;
    rdy  = !m_run || (m_slot == N - 1);
    acc  = in_valid && rdy && !fl;
    last = m_run && (m_slot == N - 1);
    m_ov = m_done && !fl;
    if (m_ov) m_od = m_fin;
    m_done = last && !fl;
    if (last) m_fin = m_cur;
    if (cfg_we) begin
      if (ok) begin m_kc = int'(cfg_taps); m_mc = int'(cfg_bits); m_err = 0; end
      else m_err = 1;
    end
    if (coef_we && int'(coef_addr) < L) m_coef[coef_addr] = coef_data;
    if (fl) begin
      for (int t = 0; t < L; t++) m_hist[t] = 0;
      m_run = 0; m_slot = 0;
    end else if (acc) begin
      for (int t = L - 1; t > 0; t--) m_hist[t] = m_hist[t-1];
      m_hist[0] = longint'($signed(in_data));
      m_cur = ref_y();
      m_run = 1; m_slot = 0;
    end else if (last) begin
      m_run = 0; m_slot = 0;
    end else if (m_run) begin
      m_slot++;
    end
    m_acc = acc;
  endtask

  // advance model after each rising edge and compare at the falling edge
  task automatic tick();
    bit exp_rdy;
    @(negedge clk);
    advance();
    exp_rdy = !m_run || (m_slot == N - 1);
    check(in_ready == exp_rdy, "R3 in_ready", longint'(in_ready), longint'(exp_rdy));
    check(out_valid == m_ov, "R3 out_valid", longint'(out_valid), longint'(m_ov));
    check(cfg_err == m_err, "R5 cfg_err", longint'(cfg_err), longint'(m_err));
    if (out_valid)
      check(longint'(out_data) == m_od, "R2 out_data", longint'(out_data), m_od);
    else
      check(longint'(out_data) == m_od, "R9 out_data hold", longint'(out_data), m_od);
  endtask

  task automatic write_cfg(input int kc, input int mc);
    cfg_we = 1; cfg_taps = TW'(kc); cfg_bits = TW'(mc);
    tick();
    cfg_we = 0;
  endtask

  task automatic write_coef(input int a, input logic [CW-1:0] d);
    coef_we = 1; coef_addr = AW'(a); coef_data = d;
    tick();
    coef_we = 0;
  endtask

  task automatic send(input logic [DW-1:0] v);
    in_valid = 1; in_data = v;
    do tick(); while (!m_acc);
    in_valid = 0;
  endtask

  task automatic drain();
    repeat (N + 3) tick();
  endtask

  int cfg_k [6] = '{3, 2, 4, 6, 12, 1};

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    ctx = "R1 reset";
    check(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    check(out_data == '0, "R1 out_data", longint'(out_data), 0);
    check(cfg_err == 1'b0, "R1 cfg_err", longint'(cfg_err), 0);

    // R8 directed example
    ctx = "R8 kc=2 mc=6";
    write_cfg(2, 6);
    write_coef(0, CW'(5));
    write_coef(1, CW'(6'h3D) | CW'(12'hA80));
    send(DW'(7));
    drain();
    check(longint'(out_data) == 35, "R8 y0", longint'(out_data), 35);
    send(DW'(-2));
    drain();
    check(longint'(out_data) == -31, "R8 y1", longint'(out_data), -31);

    // R7 all factorizations with random data, R6 random upper coefficient bits
    foreach (cfg_k[i]) begin
      int kc = cfg_k[i];
      ctx = $sformatf("R7 kc=%0d mc=%0d", kc, L / kc);
      write_cfg(kc, L / kc);
      for (int t = 0; t < kc; t++) write_coef(t, CW'($urandom));
      for (int s = 0; s < 16; s++) begin
        send(DW'($urandom));
        if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 6)) tick();
      end
      drain();
    end

    // R5 rejected configuration while streaming
    ctx = "R5 bad cfg";
    write_cfg(3, 4);
    for (int t = 0; t < 3; t++) write_coef(t, CW'($urandom));
    send(DW'($urandom));
    send(DW'($urandom));
    write_cfg(5, 3);
    check(cfg_err == 1'b1, "R5 flag", longint'(cfg_err), 1);
    for (int s = 0; s < 6; s++) send(DW'($urandom));
    drain();
    ctx = "R4 good cfg clears";
    write_cfg(6, 2);
    check(cfg_err == 1'b0, "R4 flag cleared", longint'(cfg_err), 0);

    // R4/R6 flush while a frame is running
    ctx = "R6 coef flush mid-frame";
    for (int t = 0; t < 6; t++) write_coef(t, CW'($urandom));
    for (int s = 0; s < 5; s++) send(DW'($urandom));
    tick();
    write_coef(2, CW'($urandom));
    check(out_valid == 1'b0, "R4 no output after flush", longint'(out_valid), 0);
    for (int s = 0; s < 8; s++) send(DW'($urandom));
    drain();

    ctx = "R4 cfg flush mid-frame";
    send(DW'($urandom));
    tick();
    write_cfg(4, 3);
    for (int t = 0; t < 4; t++) write_coef(t, CW'($urandom));
    for (int s = 0; s < 8; s++) send(DW'($urandom));
    drain();

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog [%s]: actual=timeout expected=completion", ctx);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule